// File: doc/BRIEF.md
# PCI Power Management Capability Register Pair

This block holds the two configuration words that a PCI function exposes for power management. The first is a read-only capability word. It describes which power states the function supports and the states from which it can raise a wake request. Its contents come from a serial-EEPROM image, and a loader presents that image as one 16-bit word with a load strobe. The same word can also be read at a second test address. The second is a control/status word. It holds the current power state, a wake-enable flag and a wake-status flag. Together these drive the PME output that requests wake-up.

The D3cold wake capability is advertised only when auxiliary power is present and the EEPROM image also grants it. While that capability is advertised, the wake flags survive a warm reset. Only a power-on reset or a software clear removes them. The configuration port has no back-pressure. A write is taken in the cycle `cfg_wr` is high. Reads are combinational from `cfg_addr` and need no strobe. The EEPROM strobe and the wake input are plain single-cycle pulses that are always accepted.

Top module: `pm_cap_regs`

## Requirements
- R1: After a power-on reset (`por_n` low), the capability word reads 0x0001: every loaded bit is 0 and the version field holds 001. The control/status word reads 0x0000 and `pme_out` is 0.
- R2: An `ee_load` pulse stores `ee_data` in the capability image. The capability word has this layout: support mask in 15:11 (bit 11 D0, bit 12 D1, bit 13 D2, bit 14 D3hot, bit 15 D3cold), D2-support in bit 10, D1-support in bit 9, device-specific-init in bit 5, PME-clock in bit 3 and version in 2:0. Bits 8:6 and 4 read 0. Address 0 and address 2 return the same value.
- R3: Configuration writes to address 0 or address 2 leave the capability word unchanged.
- R4: Capability bit 15 reads 1 only when `aux_det` is 1 and the loaded bit 15 is 1.
- R5: The PME-clock bit (bit 3) reads 0 whenever the effective support mask (bits 15:11) is all zero.
- R6: Control/status bits 1:0 hold the power state (00 D0, 01 D1, 10 D2, 11 D3hot). A write updates them only when `cfg_be[0]` is set. A write of 01 is dropped if D1-support is 0, and a write of 10 is dropped if D2-support is 0.
- R7: Control/status bit 8 is the wake-enable flag. A write updates it only when `cfg_be[1]` is set.
- R8: A `wake_evt` pulse sets the wake-status flag (control/status bit 15) whatever the value of the enable flag.
- R9: Writing 1 to bit 15 with `cfg_be[1]` set clears the status flag. Writing 0 to it, or writing with `cfg_be[1]` clear, has no effect. If a wake event arrives in the same cycle as the clear, the flag stays set.
- R10: `pme_out` is 1 exactly when the status flag and the enable flag are both 1 and the support-mask bit of the current power state is 1.
- R11: A warm reset (`warm_rst_n` low at a clock edge) returns the power state to D0. It keeps the status and enable flags when D3cold wake is advertised (bit 15 reads 1) and clears them otherwise. It does not alter the capability image.
- R12: Address 3 reads 0 and ignores writes. Unused control/status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| cfg_addr | input | 2 | Word select: 0 capability, 1 control/status, 2 capability test alias, 3 unmapped |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables for the write data |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` |
| ee_load | input | 1 | EEPROM image load strobe |
| ee_data | input | 16 | EEPROM image word |
| aux_det | input | 1 | Auxiliary power detected |
| wake_evt | input | 1 | Wake event pulse |
| pme_out | output | 1 | Wake request output, active high |

## Verification
The hardest case to reach is a warm reset that arrives while the status and enable flags are both set, under each value of `aux_det`. That needs an image that advertises D3cold, enable written through the upper byte lane, a wake pulse, and then the reset. The bench builds that sequence twice: once with auxiliary power present, where the flags must survive, and once after dropping `aux_det`, where they must clear. A second hard case is a wake pulse in the same cycle as a write-one-to-clear. The bench lines up those two pulses on a single clock edge.

// File: rtl/pm_regs_pkg.sv
package pm_regs_pkg;
  localparam int WORD_W  = 16;
  localparam int SUP_W   = 5;
  localparam int PS_W    = 2;
  localparam int VER_W   = 3;
  localparam int SUP_LSB = 11;
  localparam int D2_POS  = 10;
  localparam int D1_POS  = 9;
  localparam int DSI_POS = 5;
  localparam int CLK_POS = 3;
  localparam int STAT_POS = 15;
  localparam int EN_POS   = 8;

  typedef enum logic [1:0] {
    SEL_CAP   = 2'd0,
    SEL_CSR   = 2'd1,
    SEL_ALIAS = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [SUP_W-1:0] sup;
    logic             d2;
    logic             d1;
    logic             dsi;
    logic             clk_req;
    logic [VER_W-1:0] ver;
  } cap_img_t;
endpackage

// File: rtl/pm_cap_image.sv
module pm_cap_image
  import pm_regs_pkg::*;
#(
  parameter logic [VER_W-1:0] VER_RESET = 3'b001
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ee_load,
  input  logic [WORD_W-1:0] ee_data,
  input  logic              aux_det,
  output logic [WORD_W-1:0] cap_word,
  output logic [SUP_W-1:0]  sup_eff,
  output logic              d1_ok,
  output logic              d2_ok
);
  cap_img_t img;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      img     <= '0;
      img.ver <= VER_RESET;
    end else if (ee_load) begin
      img.sup     <= ee_data[SUP_LSB +: SUP_W];
      img.d2      <= ee_data[D2_POS];
      img.d1      <= ee_data[D1_POS];
      img.dsi     <= ee_data[DSI_POS];
      img.clk_req <= ee_data[CLK_POS];
      img.ver     <= ee_data[VER_W-1:0];
    end
  end

  // D3cold wake needs auxiliary power as well as the image grant
  assign sup_eff = {img.sup[SUP_W-1] & aux_det, img.sup[SUP_W-2:0]};
  assign d1_ok   = img.d1;
  assign d2_ok   = img.d2;

  always_comb begin
    cap_word                        = '0;
    cap_word[SUP_LSB +: SUP_W]      = sup_eff;
    cap_word[D2_POS]                = img.d2;
    cap_word[D1_POS]                = img.d1;
    cap_word[DSI_POS]               = img.dsi;
    cap_word[CLK_POS]               = img.clk_req & (|sup_eff);
    cap_word[VER_W-1:0]             = img.ver;
  end

  a_r4_d3cold_needs_aux: assert property (@(posedge clk) disable iff (!por_n)
    !aux_det |-> !cap_word[WORD_W-1]);
  a_r5_clk_needs_support: assert property (@(posedge clk) disable iff (!por_n)
    (cap_word[SUP_LSB +: SUP_W] == '0) |-> !cap_word[CLK_POS]);
  a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!por_n)
    ee_load |=> (cap_word[D2_POS:D1_POS] == $past(ee_data[D2_POS:D1_POS])));
endmodule

// File: rtl/pm_ctl_status.sv
module pm_ctl_status
  import pm_regs_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [PS_W-1:0]   wr_ps,
  input  logic              wr_enable_bit,
  input  logic              wr_status_bit,
  input  logic              wake_evt,
  input  logic [SUP_W-1:0]  sup_eff,
  input  logic              d1_ok,
  input  logic              d2_ok,
  output logic [WORD_W-1:0] csr_word,
  output logic              pme_out
);
  logic            status_q;
  logic            enable_q;
  logic [PS_W-1:0] pstate_q;
  logic            ps_legal;
  logic            keep_flags;

  always_comb begin
    unique case (wr_ps)
      2'b01:   ps_legal = d1_ok;
      2'b10:   ps_legal = d2_ok;
      default: ps_legal = 1'b1;
    endcase
  end

  assign keep_flags = sup_eff[SUP_W-1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      status_q <= 1'b0;
      enable_q <= 1'b0;
      pstate_q <= '0;
    end else if (!warm_rst_n) begin
      pstate_q <= '0;
      if (!keep_flags) begin
        status_q <= 1'b0;
        enable_q <= 1'b0;
      end
    end else begin
      if (wr_en && wr_be[0] && ps_legal) pstate_q <= wr_ps;
      if (wr_en && wr_be[1]) enable_q <= wr_enable_bit;
      if (wake_evt) status_q <= 1'b1;
      else if (wr_en && wr_be[1] && wr_status_bit) status_q <= 1'b0;
    end
  end

  always_comb begin
    csr_word              = '0;
    csr_word[STAT_POS]    = status_q;
    csr_word[EN_POS]      = enable_q;
    csr_word[PS_W-1:0]    = pstate_q;
  end

  assign pme_out = status_q & enable_q & sup_eff[pstate_q];

  a_r8_wake_sets: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst_n && wake_evt) |=> status_q);
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst_n && wr_en && wr_be[1] && wr_status_bit && !wake_evt) |=> !status_q);
  a_r6_d1_gate: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst_n && wr_en && wr_be[0] && wr_ps == 2'b01 && !d1_ok) |=> $stable(pstate_q));
  a_r11_sticky_keep: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && keep_flags && status_q) |=> status_q);
  a_r11_plain_clear: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && !keep_flags) |=> (!status_q && !enable_q && pstate_q == '0));
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_regs_pkg::*;
#(
  parameter logic [VER_W-1:0] VER_RESET = 3'b001
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic [1:0]        cfg_addr,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_be,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              ee_load,
  input  logic [WORD_W-1:0] ee_data,
  input  logic              aux_det,
  input  logic              wake_evt,
  output logic              pme_out
);
  cfg_sel_e          sel;
  logic [WORD_W-1:0] cap_word;
  logic [WORD_W-1:0] csr_word;
  logic [SUP_W-1:0]  sup_eff;
  logic              d1_ok, d2_ok;
  logic              csr_wr;

  assign sel    = cfg_sel_e'(cfg_addr);
  assign csr_wr = cfg_wr && (sel == SEL_CSR);

  pm_cap_image #(.VER_RESET(VER_RESET)) u_image (
    .clk      (clk),
    .por_n    (por_n),
    .ee_load  (ee_load),
    .ee_data  (ee_data),
    .aux_det  (aux_det),
    .cap_word (cap_word),
    .sup_eff  (sup_eff),
    .d1_ok    (d1_ok),
    .d2_ok    (d2_ok)
  );

  pm_ctl_status u_ctl (
    .clk           (clk),
    .por_n         (por_n),
    .warm_rst_n    (warm_rst_n),
    .wr_en         (csr_wr),
    .wr_be         (cfg_be),
    .wr_ps         (cfg_wdata[PS_W-1:0]),
    .wr_enable_bit (cfg_wdata[EN_POS]),
    .wr_status_bit (cfg_wdata[STAT_POS]),
    .wake_evt      (wake_evt),
    .sup_eff       (sup_eff),
    .d1_ok         (d1_ok),
    .d2_ok         (d2_ok),
    .csr_word      (csr_word),
    .pme_out       (pme_out)
  );

  always_comb begin
    unique case (sel)
      SEL_CAP, SEL_ALIAS: cfg_rdata = cap_word;
      SEL_CSR:            cfg_rdata = csr_word;
      default:            cfg_rdata = '0;
    endcase
  end

  a_r10_pme_needs_support: assert property (@(posedge clk) disable iff (!por_n)
    pme_out |-> (cap_word[SUP_LSB + csr_word[PS_W-1:0]] && csr_word[STAT_POS] && csr_word[EN_POS]));
endmodule

// File: tb/pm_cap_regs_bench.sv
`timescale 1ns/1ps
module pm_cap_regs_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic [1:0]  cfg_addr = 2'd0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        ee_load = 1'b0;
  logic [15:0] ee_data = '0;
  logic        aux_det = 1'b0;
  logic        wake_evt = 1'b0;
  logic        pme_out;
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_cap_regs u_pm_cap_regs (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ee_load(ee_load), .ee_data(ee_data), .aux_det(aux_det),
    .wake_evt(wake_evt), .pme_out(pme_out)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    cfg_addr = a;
    #0.5;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic chk_pme(logic exp, string tag);
    check(tag, {15'd0, pme_out}, {15'd0, exp});
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic eeload(logic [15:0] d);
    @(negedge clk);
    ee_data = d; ee_load = 1'b1;
    @(negedge clk);
    ee_load = 1'b0;
  endtask

  task automatic wake();
    @(negedge clk);
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  task automatic warm();
    @(negedge clk);
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
  endtask

  task automatic por();
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic t_reset();
    rd(2'd0, 16'h0001, "R1 cap after por");
    rd(2'd1, 16'h0000, "R1 csr after por");
    chk_pme(1'b0, "R1 pme after por");
  endtask

  task automatic t_cap();
    aux_det = 1'b1;
    eeload(16'hFFFF);
    rd(2'd0, 16'hFE2F, "R2 cap full image");
    rd(2'd2, 16'hFE2F, "R2 alias equals cap");
    wr(2'd0, 2'b11, 16'h0000);
    rd(2'd0, 16'hFE2F, "R3 cap write ignored");
    wr(2'd2, 2'b11, 16'h0000);
    rd(2'd2, 16'hFE2F, "R3 alias write ignored");
    @(negedge clk); aux_det = 1'b0;
    rd(2'd0, 16'h7E2F, "R4 no aux hides d3cold");
    eeload(16'h8008);
    rd(2'd0, 16'h0000, "R5 clk bit hidden with empty support");
    @(negedge clk); aux_det = 1'b1;
    rd(2'd0, 16'h8008, "R4 R5 aux restores d3cold and clk");
    eeload(16'h0208);
    rd(2'd0, 16'h0200, "R5 clk bit hidden, no support");
  endtask

  task automatic t_pstate();
    eeload(16'h0201);
    wr(2'd1, 2'b01, 16'h0002);
    rd(2'd1, 16'h0000, "R6 D2 write dropped");
    wr(2'd1, 2'b01, 16'h0001);
    rd(2'd1, 16'h0001, "R6 D1 write taken");
    wr(2'd1, 2'b01, 16'h0003);
    rd(2'd1, 16'h0003, "R6 D3hot write taken");
    wr(2'd1, 2'b10, 16'h0000);
    rd(2'd1, 16'h0003, "R6 low lane disabled");
    eeload(16'h0401);
    wr(2'd1, 2'b01, 16'h0002);
    rd(2'd1, 16'h0002, "R6 D2 write taken");
    wr(2'd1, 2'b01, 16'h0001);
    rd(2'd1, 16'h0002, "R6 D1 write dropped");
    wr(2'd1, 2'b01, 16'h0000);
    rd(2'd1, 16'h0000, "R6 back to D0");
  endtask

  task automatic t_status();
    wake();
    rd(2'd1, 16'h8000, "R8 wake sets status with enable off");
    chk_pme(1'b0, "R10 no pme with enable off");
    wr(2'd1, 2'b10, 16'h0000);
    rd(2'd1, 16'h8000, "R9 writing 0 keeps status");
    wr(2'd1, 2'b01, 16'h8000);
    rd(2'd1, 16'h8000, "R9 high lane disabled keeps status");
    wr(2'd1, 2'b10, 16'h8000);
    rd(2'd1, 16'h0000, "R9 write one clears");
  endtask

  task automatic t_pme();
    eeload(16'hF801);
    wr(2'd1, 2'b10, 16'h0100);
    rd(2'd1, 16'h0100, "R7 enable written");
    chk_pme(1'b0, "R10 no pme without status");
    wake();
    chk_pme(1'b1, "R10 pme asserted in D0");
    eeload(16'h1201);
    chk_pme(1'b0, "R10 D0 not in support mask");
    wr(2'd1, 2'b01, 16'h0001);
    chk_pme(1'b1, "R10 D1 in support mask");
    wr(2'd1, 2'b01, 16'h0003);
    chk_pme(1'b0, "R10 D3hot not in support mask");
    @(negedge clk);
    cfg_addr = 2'd1; cfg_be = 2'b10; cfg_wdata = 16'h8100; cfg_wr = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; wake_evt = 1'b0;
    rd(2'd1, 16'h8103, "R9 wake wins over clear");
    wr(2'd1, 2'b10, 16'h8100);
    rd(2'd1, 16'h0103, "R9 clear alone");
  endtask

  task automatic t_sticky();
    eeload(16'h8001);
    wake();
    rd(2'd1, 16'h8103, "R11 flags set before warm reset");
    warm();
    rd(2'd1, 16'h8100, "R11 flags kept, state to D0");
    rd(2'd0, 16'h8001, "R11 image kept over warm reset");
    @(negedge clk); aux_det = 1'b0;
    warm();
    rd(2'd1, 16'h0000, "R11 flags cleared without d3cold");
    @(negedge clk); aux_det = 1'b1;
    wr(2'd1, 2'b10, 16'h0100);
    wake();
    eeload(16'hFFFF);
    rd(2'd1, 16'h8100, "R11 flags set before por");
    por();
    rd(2'd0, 16'h0001, "R1 cap after second por");
    rd(2'd1, 16'h0000, "R11 por clears sticky flags");
    chk_pme(1'b0, "R1 pme after second por");
  endtask

  task automatic t_unmapped();
    wr(2'd3, 2'b11, 16'hFFFF);
    rd(2'd3, 16'h0000, "R12 unmapped reads zero");
    rd(2'd1, 16'h0000, "R12 unmapped write no effect");
    wr(2'd1, 2'b11, 16'h7EFC);
    rd(2'd1, 16'h0000, "R12 unused csr bits read zero");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_pstate();
    t_status();
    t_pme();
    t_sticky();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule